// File: doc/BRIEF.md
# Shared Memory Bus Arbiter

This block shares one external RAM and its address/data path between a host processor and a serial-bus protocol terminal. The processor opens an access with select and strobe. It marks the access as a read or a write, and as a RAM access or a register access. The arbiter waits a fixed settling delay, enables the external bus buffers, steers the matching RAM or external-register strobes, and then returns a one-clock ready pulse. The terminal takes the bus through a request/grant/acknowledge handshake. While it owns the bus, its own chip-select, output-enable and write strobes pass through to the RAM.

The block also keeps a DMA word-address counter that the terminal advances one word at a time. A new-protocol pulse from the terminal cancels a transfer in progress so that a superseding command can start at once. A master clear returns everything to idle. A combined reset output serves neighbouring logic, and a memory-area select output picks one of two RAM areas. Every control input passes through one register stage on the system clock. Active-low pins are inverted at the boundary, and all internal logic is active-high.

Top module: `smba_top`

## Requirements
- R1: With the bus free, the buffer enable `io_en_n` goes low at the second rising edge after the edge that first samples `cpu_sel` and `cpu_strobe` both high. It stays low for two clock cycles (CPU_DLY = 2).
- R2: `cpu_rdy` is high for exactly one cycle. That cycle is the second of the two cycles in which `io_en_n` is low.
- R3: After an access completes, no new access starts until `cpu_sel` and `cpu_strobe` have been seen low together. A strobe held high afterwards leaves `io_en_n` high.
- R4: If the terminal owns the bus when the processor strobes, the processor waits. `io_en_n` goes low at the second rising edge after the edge at which `bus_grant` falls.
- R5: `bus_grant` rises at the second rising edge after `bus_req` goes high while idle. It stays high until the request is removed. If a request and a processor strobe are first sampled in the same cycle while idle, the terminal is granted first. `io_en_n` and `bus_grant` are never active together.
- R6: A bus request that arrives after a processor access has started does not interrupt it. `bus_grant` rises one edge after the access ends, which is the edge after the `cpu_rdy` cycle.
- R7: The terminal strobes `dev_cs_n`, `dev_oe_n` and `dev_we_n` reach `ram_cs_n`, `ram_oe_n` and `ram_we_n` one edge after they are applied, but only once `bus_ack` has been sampled in the granted state. Before that the RAM strobes stay high.
- R8: During the two enabled cycles of a processor access, `cpu_mem` = 1 selects RAM: `ram_cs_n` is low, with `ram_oe_n` low for a read (`cpu_rd` = 1) or `ram_we_n` low for a write. `cpu_mem` = 0 selects the external registers: `ext_en_n` is low for a read or `ext_ld_n` is low for a write. The strobes of the other group stay high.
- R9: Each rising edge of `adr_inc` while the terminal owns the bus adds one to `dma_addr`, modulo 2^ADDR_W. A pulse held for several cycles counts once, and pulses outside ownership are ignored.
- R10: A low pulse on `new_proto_n` clears `dma_addr` to zero and drops `bus_grant` for one cycle. If the request is still present, the grant returns on the next edge.
- R11: A low on `mclr_n` clears `dma_addr`, sets `area_sel` to 0 and drops `bus_grant`, all at the second edge after it is applied.
- R12: `ext_rst_n` is low one edge after `cpu_reset` is high or `mclr_n` is low, and goes high again one edge after both are released.
- R13: `area_sel` (0 = area A, 1 = area B) follows `area_req` two edges later while the terminal does not own the bus. While the terminal owns the bus it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_sel | input | 1 | Processor selects the block |
| cpu_strobe | input | 1 | Processor transfer strobe |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_mem | input | 1 | 1 = RAM access, 0 = register access |
| cpu_reset | input | 1 | Processor reset request |
| cpu_rdy | output | 1 | One-cycle ready pulse |
| io_en_n | output | 1 | Bus buffer enable, active low |
| bus_req | input | 1 | Terminal bus request |
| bus_grant | output | 1 | Bus grant to terminal |
| bus_ack | input | 1 | Terminal confirms grant |
| dev_cs_n | input | 1 | Terminal RAM chip select, active low |
| dev_oe_n | input | 1 | Terminal RAM output enable, active low |
| dev_we_n | input | 1 | Terminal RAM write, active low |
| adr_inc | input | 1 | DMA address advance |
| new_proto_n | input | 1 | New-protocol abort pulse, active low |
| mclr_n | input | 1 | Master clear, active low |
| area_req | input | 1 | Requested memory area |
| area_sel | output | 1 | Active memory area, 0 = A |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write, active low |
| ext_en_n | output | 1 | External register read enable, active low |
| ext_ld_n | output | 1 | External register load, active low |
| dma_addr | output | ADDR_W | DMA word address |
| ext_rst_n | output | 1 | Combined reset output, active low |

## Verification
Two functions can fall in the same cycle: the processor's strobe and the terminal's request. The bench provokes them in two ways. First, it raises both in the same cycle while the arbiter is idle. The expected result is a grant at the second edge, and the processor held off until two edges after the grant falls. Second, it raises the request one cycle into the processor's settling delay. The expected result is that the access completes with its ready pulse and the grant follows one edge later. In both cases the bench compares the cycle-by-cycle levels of `bus_grant`, `io_en_n` and `cpu_rdy` against edge counts derived from the requirements.

// File: rtl/smba_pkg.sv
package smba_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_ACT,
        ST_RDY,
        ST_GRANT,
        ST_DEV
    } arb_state_e;

    // Sampled control inputs, all active high
    typedef struct packed {
        logic sel;
        logic stb;
        logic rd;
        logic mem;
        logic req;
        logic ack;
        logic inc;
        logic abort;
        logic mclr;
        logic cpu_rst;
        logic area;
        logic dcs;
        logic doe;
        logic dwe;
    } ctl_s;

    typedef struct packed {
        logic cs;
        logic oe;
        logic we;
    } ram_strb_s;

    function automatic ram_strb_s cpu_ram_strobes(input logic active, input logic mem, input logic rd);
        ram_strb_s r;
        r.cs = active & mem;
        r.oe = active & mem & rd;
        r.we = active & mem & ~rd;
        return r;
    endfunction

endpackage

// File: rtl/smba_insample.sv
module smba_insample
    import smba_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_s raw,
    output ctl_s smp
);

    always_ff @(posedge clk) begin
        if (rst) smp <= '0;
        else     smp <= raw;
    end

endmodule

// File: rtl/smba_arb.sv
module smba_arb
    import smba_pkg::*;
#(
    parameter int CPU_DLY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  ctl_s       smp,
    output arb_state_e state,
    output logic       cyc_rd,
    output logic       cyc_mem
);

    localparam int CW = $clog2(CPU_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(CPU_DLY - 2);

    arb_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          armed_q, armed_d;
    logic          rd_q, rd_d, mem_q, mem_d;
    logic          cpu_pend, dev_drop;

    always_comb begin
        cpu_pend = smp.sel & smp.stb & armed_q;
        dev_drop = ~smp.req | smp.abort;
        st_d  = st_q;
        cnt_d = cnt_q;
        rd_d  = rd_q;
        mem_d = mem_q;
        case (st_q)
            ST_IDLE: begin
                if (smp.req) begin
                    st_d = ST_GRANT;
                end else if (cpu_pend) begin
                    st_d  = ST_DELAY;
                    cnt_d = '0;
                    rd_d  = smp.rd;
                    mem_d = smp.mem;
                end
            end
            ST_DELAY: begin
                if (cnt_q == LAST) st_d = ST_ACT;
                else               cnt_d = cnt_q + 1'b1;
            end
            ST_ACT:   st_d = ST_RDY;
            ST_RDY:   st_d = ST_IDLE;
            ST_GRANT: begin
                if (dev_drop)     st_d = ST_IDLE;
                else if (smp.ack) st_d = ST_DEV;
            end
            ST_DEV:   if (dev_drop) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (st_q == ST_RDY)            armed_d = 1'b0;
        else if (!(smp.sel & smp.stb)) armed_d = 1'b1;
        else                           armed_d = armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst || smp.mclr) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            armed_q <= 1'b1;
            rd_q    <= 1'b0;
            mem_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
            rd_q    <= rd_d;
            mem_q   <= mem_d;
        end
    end

    assign state   = st_q;
    assign cyc_rd  = rd_q;
    assign cyc_mem = mem_q;

endmodule

// File: rtl/smba_addr_ctr.sv
module smba_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);

    logic inc_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            inc_prev_q <= 1'b0;
        end else begin
            inc_prev_q <= inc;
            if (clr)                          addr <= '0;
            else if (en && inc && !inc_prev_q) addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/smba_top.sv
module smba_top
    import smba_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CPU_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_strobe,
    input  logic              cpu_rd,
    input  logic              cpu_mem,
    input  logic              cpu_reset,
    output logic              cpu_rdy,
    output logic              io_en_n,
    input  logic              bus_req,
    output logic              bus_grant,
    input  logic              bus_ack,
    input  logic              dev_cs_n,
    input  logic              dev_oe_n,
    input  logic              dev_we_n,
    input  logic              adr_inc,
    input  logic              new_proto_n,
    input  logic              mclr_n,
    input  logic              area_req,
    output logic              area_sel,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              ext_en_n,
    output logic              ext_ld_n,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              ext_rst_n
);

    ctl_s       raw, smp;
    arb_state_e arb_state;
    logic       cyc_rd, cyc_mem;
    logic       cpu_phase, dev_own;
    ram_strb_s  cpu_strb, ram_strb;
    logic       area_q;

    always_comb begin
        raw.sel     = cpu_sel;
        raw.stb     = cpu_strobe;
        raw.rd      = cpu_rd;
        raw.mem     = cpu_mem;
        raw.req     = bus_req;
        raw.ack     = bus_ack;
        raw.inc     = adr_inc;
        raw.abort   = ~new_proto_n;
        raw.mclr    = ~mclr_n;
        raw.cpu_rst = cpu_reset;
        raw.area    = area_req;
        raw.dcs     = ~dev_cs_n;
        raw.doe     = ~dev_oe_n;
        raw.dwe     = ~dev_we_n;
    end

    smba_insample u_insample (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .smp (smp)
    );

    smba_arb #(.CPU_DLY(CPU_DLY)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .state   (arb_state),
        .cyc_rd  (cyc_rd),
        .cyc_mem (cyc_mem)
    );

    assign dev_own = (arb_state == ST_DEV);

    smba_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .clr  (smp.mclr | smp.abort),
        .en   (dev_own),
        .inc  (smp.inc),
        .addr (dma_addr)
    );

    always_ff @(posedge clk) begin
        if (rst || smp.mclr) area_q <= 1'b0;
        else if (!dev_own)   area_q <= smp.area;
    end

    always_comb begin
        cpu_phase = (arb_state == ST_ACT) || (arb_state == ST_RDY);
        cpu_strb  = cpu_ram_strobes(cpu_phase, cyc_mem, cyc_rd);
        if (dev_own) begin
            ram_strb.cs = smp.dcs;
            ram_strb.oe = smp.doe;
            ram_strb.we = smp.dwe;
        end else begin
            ram_strb = cpu_strb;
        end
    end

    assign io_en_n   = ~cpu_phase;
    assign cpu_rdy   = (arb_state == ST_RDY);
    assign bus_grant = (arb_state == ST_GRANT) || dev_own;
    assign ram_cs_n  = ~ram_strb.cs;
    assign ram_oe_n  = ~ram_strb.oe;
    assign ram_we_n  = ~ram_strb.we;
    assign ext_en_n  = ~(cpu_phase & ~cyc_mem & cyc_rd);
    assign ext_ld_n  = ~(cpu_phase & ~cyc_mem & ~cyc_rd);
    assign area_sel  = area_q;
    assign ext_rst_n = ~(smp.cpu_rst | smp.mclr);

endmodule

// File: rtl/smba_chk.sv
module smba_chk
    import smba_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mclr_n,
    input logic              io_en_n,
    input logic              bus_grant,
    input logic              cpu_rdy,
    input logic              ext_rst_n,
    input logic              area_sel,
    input logic [ADDR_W-1:0] dma_addr,
    input arb_state_e        state,
    input ctl_s              smp
);

    p_rdy_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |=> !cpu_rdy);

    p_rdy_in_enable_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rdy |-> !io_en_n);

    p_excl_owner_r5: assert property (@(posedge clk) disable iff (rst)
        !(!io_en_n && bus_grant));

    p_grant_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_grant && smp.req && !smp.abort && !smp.mclr) |=> bus_grant);

    p_addr_step_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_addr != $past(dma_addr)) |->
            ((dma_addr == $past(dma_addr) + 1'b1) || (dma_addr == '0)));

    p_mclr_rstout_r12: assert property (@(posedge clk) disable iff (rst)
        !mclr_n |=> !ext_rst_n);

    p_area_hold_r13: assert property (@(posedge clk) disable iff (rst)
        ($past(state == ST_DEV) && !$past(smp.mclr)) |-> $stable(area_sel));

endmodule

bind smba_top smba_chk #(.ADDR_W(ADDR_W)) i_smba_chk (
    .clk       (clk),
    .rst       (rst),
    .mclr_n    (mclr_n),
    .io_en_n   (io_en_n),
    .bus_grant (bus_grant),
    .cpu_rdy   (cpu_rdy),
    .ext_rst_n (ext_rst_n),
    .area_sel  (area_sel),
    .dma_addr  (dma_addr),
    .state     (arb_state),
    .smp       (smp)
);

// File: tb/test_smba_top.sv
module test_smba_top;

    localparam int AW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, cpu_sel, cpu_strobe, cpu_rd, cpu_mem, cpu_reset;
    logic cpu_rdy, io_en_n, bus_req, bus_grant, bus_ack;
    logic dev_cs_n, dev_oe_n, dev_we_n, adr_inc, new_proto_n, mclr_n;
    logic area_req, area_sel, ram_cs_n, ram_oe_n, ram_we_n, ext_en_n, ext_ld_n;
    logic [AW-1:0] dma_addr;
    logic ext_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    logic [AW-1:0] exp_addr;

    smba_top #(.ADDR_W(AW), .CPU_DLY(2)) i_smba_top (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_strobe(cpu_strobe),
        .cpu_rd(cpu_rd), .cpu_mem(cpu_mem), .cpu_reset(cpu_reset),
        .cpu_rdy(cpu_rdy), .io_en_n(io_en_n), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_ack(bus_ack), .dev_cs_n(dev_cs_n),
        .dev_oe_n(dev_oe_n), .dev_we_n(dev_we_n), .adr_inc(adr_inc),
        .new_proto_n(new_proto_n), .mclr_n(mclr_n), .area_req(area_req),
        .area_sel(area_sel), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .ext_en_n(ext_en_n), .ext_ld_n(ext_ld_n),
        .dma_addr(dma_addr), .ext_rst_n(ext_rst_n)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cpu_access(input logic rd, input logic mem);
        cpu_rd = rd; cpu_mem = mem; cpu_sel = 1'b1; cpu_strobe = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            logic on;
            cyc();
            on = (k == 3) || (k == 4);
            chk("R1 io_en_n", io_en_n, !on);
            chk("R2 cpu_rdy", cpu_rdy, k == 4);
            chk("R8 ram_cs_n", ram_cs_n, !(on && mem));
            chk("R8 ram_oe_n", ram_oe_n, !(on && mem && rd));
            chk("R8 ram_we_n", ram_we_n, !(on && mem && !rd));
            chk("R8 ext_en_n", ext_en_n, !(on && !mem && rd));
            chk("R8 ext_ld_n", ext_ld_n, !(on && !mem && !rd));
        end
        cpu_sel = 1'b0; cpu_strobe = 1'b0;
        cyc(); cyc();
    endtask

    task automatic dev_take();
        bus_req = 1'b1; bus_ack = 1'b1;
        repeat (4) cyc();
        chk("R5 grant held", bus_grant, 1);
    endtask

    task automatic dev_release();
        bus_req = 1'b0; bus_ack = 1'b0;
        repeat (3) cyc();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_sel = 0; cpu_strobe = 0; cpu_rd = 0; cpu_mem = 0; cpu_reset = 0;
        bus_req = 0; bus_ack = 0; dev_cs_n = 1; dev_oe_n = 1; dev_we_n = 1;
        adr_inc = 0; new_proto_n = 1; mclr_n = 1; area_req = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // reset state
        chk("R1 reset io_en_n", io_en_n, 1);
        chk("R2 reset cpu_rdy", cpu_rdy, 0);
        chk("R5 reset grant", bus_grant, 0);
        chk("R9 reset addr", dma_addr, 0);
        chk("R13 reset area", area_sel, 0);
        chk("R12 reset rst out", ext_rst_n, 1);
        chk("R7 reset ram_cs_n", ram_cs_n, 1);

        // R1/R2/R8 sweep over read/write x ram/register
        for (int m = 0; m < 4; m++) cpu_access(m[0], m[1]);

        // R3 strobe held after completion
        cpu_rd = 1; cpu_mem = 1; cpu_sel = 1; cpu_strobe = 1;
        repeat (5) cyc();
        for (int k = 0; k < 6; k++) begin
            cyc();
            chk("R3 no restart", io_en_n, 1);
        end
        cpu_sel = 0; cpu_strobe = 0;
        cyc(); cyc();
        cpu_access(0, 1);

        // R6 request arrives during processor access
        cpu_rd = 0; cpu_mem = 1; cpu_sel = 1; cpu_strobe = 1;
        cyc();
        bus_req = 1;
        for (int k = 2; k <= 6; k++) begin
            cyc();
            chk("R6 grant deferred", bus_grant, k == 6);
            chk("R6 access completes", io_en_n, !((k == 3) || (k == 4)));
        end
        bus_req = 0; cpu_sel = 0; cpu_strobe = 0;
        repeat (3) cyc();
        chk("R6 grant released", bus_grant, 0);

        // R5 strobe and request together while idle
        cpu_rd = 1; cpu_mem = 0; cpu_sel = 1; cpu_strobe = 1; bus_req = 1;
        for (int k = 1; k <= 5; k++) begin
            cyc();
            chk("R5 device first", bus_grant, k >= 2);
            chk("R5 cpu waits", io_en_n, 1);
        end
        bus_req = 0;
        for (int k = 1; k <= 4; k++) begin
            cyc();
            chk("R4 after release", io_en_n, k != 4);
            chk("R4 grant falls", bus_grant, k < 2);
        end
        cpu_sel = 0; cpu_strobe = 0;
        repeat (3) cyc();

        // R7 pass-through only after acknowledge
        dev_cs_n = 0; bus_req = 1;
        cyc(); cyc();
        chk("R5 grant rises", bus_grant, 1);
        cyc();
        chk("R7 no pass before ack", ram_cs_n, 1);
        bus_ack = 1;
        cyc();
        chk("R7 ack not yet owned", ram_cs_n, 1);
        cyc();
        chk("R7 pass after ack", ram_cs_n, 0);
        for (int v = 0; v < 8; v++) begin
            dev_cs_n = v[0]; dev_oe_n = v[1]; dev_we_n = v[2];
            cyc();
            chk("R7 ram_cs_n", ram_cs_n, v[0]);
            chk("R7 ram_oe_n", ram_oe_n, v[1]);
            chk("R7 ram_we_n", ram_we_n, v[2]);
            chk("R7 ext idle", ext_en_n & ext_ld_n, 1);
        end
        dev_cs_n = 1; dev_oe_n = 1; dev_we_n = 1;
        cyc();

        // R9 counting with wrap
        exp_addr = '0;
        for (int i = 0; i < 20; i++) begin
            adr_inc = 1; cyc();
            adr_inc = 0; cyc();
            exp_addr = exp_addr + 1'b1;
            chk("R9 increment", dma_addr, exp_addr);
        end
        adr_inc = 1; repeat (4) cyc();
        adr_inc = 0; cyc();
        exp_addr = exp_addr + 1'b1;
        chk("R9 long pulse once", dma_addr, exp_addr);

        // R10 new-protocol abort
        new_proto_n = 0; cyc();
        new_proto_n = 1; cyc();
        chk("R10 grant dropped", bus_grant, 0);
        chk("R10 addr cleared", dma_addr, 0);
        cyc();
        chk("R10 regranted", bus_grant, 1);
        cyc();
        for (int i = 0; i < 2; i++) begin
            adr_inc = 1; cyc();
            adr_inc = 0; cyc();
        end
        chk("R10 counts after takeover", dma_addr, 2);

        // R11/R12 master clear
        mclr_n = 0; cyc();
        chk("R12 mclr rst out", ext_rst_n, 0);
        mclr_n = 1; cyc();
        chk("R11 addr cleared", dma_addr, 0);
        chk("R11 grant dropped", bus_grant, 0);
        chk("R11 area A", area_sel, 0);
        chk("R12 rst out released", ext_rst_n, 1);
        dev_release();

        // R9 increment ignored outside ownership
        adr_inc = 1; cyc();
        adr_inc = 0; cyc(); cyc();
        chk("R9 ignored when idle", dma_addr, 0);

        // R12 processor reset request
        cpu_reset = 1; cyc();
        chk("R12 cpu reset", ext_rst_n, 0);
        cpu_reset = 0; cyc();
        chk("R12 cpu reset released", ext_rst_n, 1);

        // R13 area follows when idle, holds while owned
        area_req = 1; cyc();
        chk("R13 area latency", area_sel, 0);
        cyc();
        chk("R13 area follows", area_sel, 1);
        dev_take();
        area_req = 0;
        repeat (4) cyc();
        chk("R13 area held", area_sel, 1);
        bus_req = 0; bus_ack = 0;
        cyc(); cyc();
        chk("R13 area held to release", area_sel, 1);
        cyc();
        chk("R13 area follows again", area_sel, 0);
        cyc();

        // R4 contention with RAM read
        dev_take();
        cpu_rd = 1; cpu_mem = 1; cpu_sel = 1; cpu_strobe = 1;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R4 cpu blocked", io_en_n, 1);
            chk("R5 grant kept", bus_grant, 1);
        end
        bus_req = 0; bus_ack = 0;
        for (int k = 1; k <= 5; k++) begin
            cyc();
            chk("R4 grant", bus_grant, k < 2);
            chk("R4 io_en_n", io_en_n, !((k == 4) || (k == 5)));
            chk("R4 cpu_rdy", cpu_rdy, k == 5);
            chk("R8 ram_oe_n", ram_oe_n, !((k == 4) || (k == 5)));
        end
        cpu_sel = 0; cpu_strobe = 0;
        repeat (3) cyc();

        summary();
        $finish;
    end

endmodule